// File: doc/BRIEF.md
# Leaf Descriptor Attribute Merge and Access Permission Check

This block sits at the end of a page-table walk. It receives the final leaf descriptor, the attribute bits gathered from the table descriptors above it, the level at which the walk stopped, and the access being attempted: privileged or user, and read, write or execute. From these it forms a 22-bit merged attribute word. The table bits can tighten the leaf's own permissions but never loosen them. The block then checks the access and reports either a read/write/execute permission mask or a fault code.

The checks run in a fixed priority order, and the first one that fails sets the fault type. The access flag is checked first. User access rights come next, then execute-never, then write protection. When an execute-never or write-protect bit is set and the access is of a different kind, there is no fault: the matching permission is simply removed from the mask. All results are registered. They appear one clock after the request is marked valid and are held until the next valid request.

Top module: `attr_perm_check`

## Requirements
- R1: The attribute word takes descriptor bits [11:2] into bits [9:0] and descriptor bits [63:52] into bits [21:10]. Table bit 0 is ORed into attribute bit 11 (privileged execute-never). Table bit 1 is ORed into bit 12 (execute-never). Table bit 3 is ORed into bit 5 (write forbidden).
- R2: When table bit 2 is set, attribute bit 4 (user access allowed) is cleared, whatever the descriptor holds.
- R3: If attribute bit 8 (access flag) is clear, the result is an access fault of type 2. This check wins over every other check.
- R4: If the access flag is set, a user access (user input 1) with attribute bit 4 clear is a permission fault of type 3.
- R5: Execute is forbidden when attribute bit 12 is set, or when the access is privileged and bit 11 is set. In that case an execute access (type code 2) is a permission fault of type 3, and any other access succeeds with mask bit 2 (execute) cleared.
- R6: When attribute bit 5 is set, a write access (type code 1) is a permission fault of type 3, and any other access succeeds with mask bit 1 (write) cleared. This check comes after R5.
- R7: A fault code has bit 9 set, the fault type in bits [5:2], the walk level in bits [1:0], and zeros elsewhere. When there is no fault, the fault code is zero.
- R8: With no fault, the permission mask starts as 3'b111 (bit 0 read, bit 1 write, bit 2 execute) before any bit is removed. On a fault, the mask is zero and the fault flag is 1.
- R9: Output valid is high exactly one cycle after input valid. The other outputs change only one cycle after a valid input and otherwise hold their values. A synchronous active-low reset clears every output to zero.
- R10: Access type code 3 is treated exactly like a read (code 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| leaf_desc | input | 64 | Final leaf descriptor |
| tbl_attr | input | 5 | Accumulated table attribute bits |
| walk_level | input | 2 | Walk level of the leaf |
| is_user | input | 1 | 1 = user access, 0 = privileged |
| acc_type | input | 2 | 0 read, 1 write, 2 execute, 3 treated as read |
| out_valid | output | 1 | Result present |
| out_fault | output | 1 | 1 = fault_code meaningful, 0 = perm_mask meaningful |
| fault_code | output | 10 | Fault code |
| perm_mask | output | 3 | Permission mask: bit 0 R, bit 1 W, bit 2 X |
| attr_word | output | 22 | Merged attribute word |

## Verification
The result register is overwritten on every valid request, so an internal error shows up at the ports one cycle after the request that triggered it. A wrong attribute word shows directly in the matching bit of the word. A check placed in the wrong priority order shows as the wrong fault type in bits [5:2], or as a fault where a mask with a bit removed was expected. The bench therefore includes directed cases where two checks fail at once, so that the priority order decides the result. A stale or wrongly held output shows on the first cycle without a request.

// File: rtl/attr_perm_pkg.sv
// Package: shared widths, bit positions and encodings for the
// descriptor attribute merge and permission checker.
package attr_perm_pkg;
    parameter int DESC_W   = 64;
    parameter int TATTR_W  = 5;
    parameter int LVL_W    = 2;
    parameter int LOW_LSB  = 2;
    parameter int LOW_W    = 10;
    parameter int HIGH_LSB = 52;
    parameter int HIGH_W   = 12;
    parameter int ATTR_W   = LOW_W + HIGH_W;
    parameter int FCODE_W  = 10;
    parameter int FTYPE_W  = 4;
    parameter int PERM_W   = 3;

    // Attribute word bit positions
    parameter int AB_USER  = 4;
    parameter int AB_WPROT = 5;
    parameter int AB_AFLAG = 8;
    parameter int AB_PXN   = 11;
    parameter int AB_XN    = 12;

    // Table attribute bit positions
    parameter int TB_PXN   = 0;
    parameter int TB_XN    = 1;
    parameter int TB_NOUSR = 2;
    parameter int TB_WPROT = 3;

    // Permission mask bit positions
    parameter int PM_R = 0;
    parameter int PM_W = 1;
    parameter int PM_X = 2;

    parameter int FC_MARK = 9;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [FTYPE_W-1:0] {
        FT_NONE   = 4'd0,
        FT_ACCESS = 4'd2,
        FT_PERM   = 4'd3
    } ftype_e;
endpackage

// File: rtl/attr_merge.sv
// Module: attr_merge
// Builds the merged attribute word from the leaf descriptor fields and
// the accumulated table attribute bits. It is purely combinational.
// Table bits can only restrict access. The no-user table bit acts in
// inverted sense: it clears the user-allowed attribute bit.
module attr_merge
    import attr_perm_pkg::*;
(
    input  logic [DESC_W-1:0]  desc,
    input  logic [TATTR_W-1:0] tbl,
    output logic [ATTR_W-1:0]  attr
);
    logic [ATTR_W-1:0] raw;

    // Copy the low and high descriptor fields into the word
    genvar gi;
    generate
        for (gi = 0; gi < LOW_W; gi++) begin : g_low
            assign raw[gi] = desc[LOW_LSB + gi];
        end
        for (gi = 0; gi < HIGH_W; gi++) begin : g_high
            assign raw[LOW_W + gi] = desc[HIGH_LSB + gi];
        end
    endgenerate

    // Apply the table restrictions on top of the leaf bits
    always_comb begin
        attr            = raw;
        attr[AB_PXN]    = raw[AB_PXN]   | tbl[TB_PXN];
        attr[AB_XN]     = raw[AB_XN]    | tbl[TB_XN];
        attr[AB_WPROT]  = raw[AB_WPROT] | tbl[TB_WPROT];
        attr[AB_USER]   = raw[AB_USER]  & ~tbl[TB_NOUSR];
    end
endmodule

// File: rtl/perm_eval.sv
// Module: perm_eval
// Runs the ordered checks on a merged attribute word: access flag,
// user rights, execute-never, then write protect. It returns a
// permission mask or a fault type. It is combinational and assumes a
// merged word from attr_merge. Access code 3 takes the read path.
module perm_eval
    import attr_perm_pkg::*;
(
    input  logic [ATTR_W-1:0]  attr,
    input  logic               is_user,
    input  acc_e               acc,
    input  logic [LVL_W-1:0]   level,
    output logic               fault,
    output logic [FCODE_W-1:0] code,
    output logic [PERM_W-1:0]  mask
);
    logic   no_exec;
    logic   no_write;
    ftype_e ftype;

    // Work out which execute and write restrictions apply
    always_comb begin
        no_exec  = attr[AB_XN] | (~is_user & attr[AB_PXN]);
        no_write = attr[AB_WPROT];
    end

    // Priority chain: the first failing check sets the fault type
    always_comb begin
        ftype = FT_NONE;
        if (!attr[AB_AFLAG])
            ftype = FT_ACCESS;
        else if (is_user && !attr[AB_USER])
            ftype = FT_PERM;
        else if (no_exec && acc == ACC_EXEC)
            ftype = FT_PERM;
        else if (no_write && acc == ACC_WRITE)
            ftype = FT_PERM;
    end

    // Build the mask or the fault code from the chain result
    always_comb begin
        fault = (ftype != FT_NONE);
        code  = '0;
        mask  = '0;
        if (fault) begin
            code[FC_MARK]          = 1'b1;
            code[2 +: FTYPE_W]     = ftype;
            code[LVL_W-1:0]        = level;
        end else begin
            mask[PM_R] = 1'b1;
            mask[PM_W] = ~no_write;
            mask[PM_X] = ~no_exec;
        end
    end
endmodule

// File: rtl/attr_perm_check.sv
// Module: attr_perm_check (top)
// Merges the leaf and table attributes, checks the requested access,
// and registers the mask or fault code with a one-cycle valid. The
// result registers load only on a valid request and hold otherwise.
// The reset is synchronous and active low.
module attr_perm_check
    import attr_perm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [DESC_W-1:0]    leaf_desc,
    input  logic [TATTR_W-1:0]   tbl_attr,
    input  logic [LVL_W-1:0]     walk_level,
    input  logic                 is_user,
    input  logic [1:0]           acc_type,
    output logic                 out_valid,
    output logic                 out_fault,
    output logic [FCODE_W-1:0]   fault_code,
    output logic [PERM_W-1:0]    perm_mask,
    output logic [ATTR_W-1:0]    attr_word
);
    logic [ATTR_W-1:0]  merged;
    logic               f_nxt;
    logic [FCODE_W-1:0] c_nxt;
    logic [PERM_W-1:0]  m_nxt;

    attr_merge u_merge (
        .desc (leaf_desc),
        .tbl  (tbl_attr),
        .attr (merged)
    );

    perm_eval u_eval (
        .attr    (merged),
        .is_user (is_user),
        .acc     (acc_e'(acc_type)),
        .level   (walk_level),
        .fault   (f_nxt),
        .code    (c_nxt),
        .mask    (m_nxt)
    );

    // Valid pipeline stage
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers, loaded only on a valid request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_fault  <= 1'b0;
            fault_code <= '0;
            perm_mask  <= '0;
            attr_word  <= '0;
        end else if (in_valid) begin
            out_fault  <= f_nxt;
            fault_code <= c_nxt;
            perm_mask  <= m_nxt;
            attr_word  <= merged;
        end
    end
endmodule

// File: rtl/attr_perm_check_sva.sv
// Module: attr_perm_check_sva
// Checker bound to attr_perm_check. It relates the registered outputs
// to the inputs of the previous cycle and to each other.
module attr_perm_check_sva
    import attr_perm_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 is_user,
    input logic [1:0]           acc_type,
    input logic                 out_valid,
    input logic                 out_fault,
    input logic [FCODE_W-1:0]   fault_code,
    input logic [PERM_W-1:0]    perm_mask,
    input logic [ATTR_W-1:0]    attr_word
);
    assert_valid_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(perm_mask) && $stable(fault_code) && $stable(attr_word));

    assert_aflag_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !attr_word[AB_AFLAG] |-> out_fault && fault_code[5:2] == 4'd2);

    assert_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(is_user) && !attr_word[AB_USER] |-> out_fault);

    assert_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(acc_type) == 2'd2 && attr_word[AB_XN] |-> out_fault);

    assert_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(acc_type) == 2'd1 && attr_word[AB_WPROT] |-> out_fault);

    assert_code_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fault |-> fault_code[FC_MARK] && fault_code[8:6] == 3'd0
            && (fault_code[5:2] == 4'd2 || fault_code[5:2] == 4'd3));

    assert_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_fault ? perm_mask == '0 : (perm_mask[PM_R] && fault_code == '0)));
endmodule

bind attr_perm_check attr_perm_check_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .is_user    (is_user),
    .acc_type   (acc_type),
    .out_valid  (out_valid),
    .out_fault  (out_fault),
    .fault_code (fault_code),
    .perm_mask  (perm_mask),
    .attr_word  (attr_word)
);

// File: tb/attr_perm_check_test.sv
// Bench for attr_perm_check: a behavioural reference model, compared
// with the outputs at every falling edge.
module attr_perm_check_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] leaf_desc = '0;
    logic [4:0]  tbl_attr = '0;
    logic [1:0]  walk_level = '0;
    logic        is_user = 1'b0;
    logic [1:0]  acc_type = '0;
    logic        out_valid, out_fault;
    logic [9:0]  fault_code;
    logic [2:0]  perm_mask;
    logic [21:0] attr_word;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Expected output state
    logic        e_valid = 0, e_fault = 0;
    logic [9:0]  e_code = 0;
    logic [2:0]  e_mask = 0;
    logic [21:0] e_attr = 0;

    always #2.5 clk = ~clk;

    attr_perm_check uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .leaf_desc(leaf_desc),
        .tbl_attr(tbl_attr), .walk_level(walk_level), .is_user(is_user),
        .acc_type(acc_type), .out_valid(out_valid), .out_fault(out_fault),
        .fault_code(fault_code), .perm_mask(perm_mask), .attr_word(attr_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R9 out_valid", 32'(out_valid), 32'(e_valid));
        chk("R1 R2 attr_word", 32'(attr_word), 32'(e_attr));
        chk("R3 R4 R5 R6 out_fault", 32'(out_fault), 32'(e_fault));
        chk("R7 fault_code", 32'(fault_code), 32'(e_code));
        chk("R5 R6 R8 R10 perm_mask", 32'(perm_mask), 32'(e_mask));
    endtask

    // Reference model of one request
    task automatic model(input logic [63:0] d, input logic [4:0] t, input logic [1:0] l,
                         input logic u, input logic [1:0] a);
        logic [21:0] at;
        int ft;
        logic [2:0] m;
        at = {d[63:52], d[11:2]};
        if (t[0]) at[11] = 1'b1;
        if (t[1]) at[12] = 1'b1;
        if (t[3]) at[5] = 1'b1;
        if (t[2]) at[4] = 1'b0;
        ft = 0;
        m = 3'b111;
        if (!at[8]) ft = 2;
        else if (u && !at[4]) ft = 3;
        else begin
            if (at[12] || (!u && at[11])) begin
                if (a == 2'd2) ft = 3; else m[2] = 1'b0;
            end
            if (ft == 0 && at[5]) begin
                if (a == 2'd1) ft = 3; else m[1] = 1'b0;
            end
        end
        e_attr = at;
        if (ft != 0) begin
            e_fault = 1'b1;
            e_mask  = 3'b000;
            e_code  = 10'h200 | 10'(ft << 2) | 10'(l);
        end else begin
            e_fault = 1'b0;
            e_mask  = m;
            e_code  = 10'h000;
        end
    endtask

    // One cycle: check the previous result, then apply the next request
    task automatic step(input logic v, input logic [63:0] d, input logic [4:0] t,
                        input logic [1:0] l, input logic u, input logic [1:0] a);
        @(negedge clk);
        compare();
        in_valid = v; leaf_desc = d; tbl_attr = t; walk_level = l;
        is_user = u; acc_type = a;
        e_valid = v;
        if (v) model(d, t, l, u, a);
    endtask

    // Descriptor builder: af=desc[10], user=desc[6], wprot=desc[7],
    // pxn=desc[53], xn=desc[54]
    function automatic logic [63:0] dsc(input logic af, input logic usr, input logic wp,
                                        input logic pxn, input logic xn);
        logic [63:0] d;
        d = 64'h0000_0000_0000_0003;
        d[10] = af; d[6] = usr; d[7] = wp; d[53] = pxn; d[54] = xn;
        return d;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare();                             // reset state, R9
        rst_n = 1'b1;
        step(0, 64'h0, 5'h0, 2'd0, 0, 2'd0);   // idle, still zero
        // R8: everything allowed, privileged read
        step(1, dsc(1,1,0,0,0), 5'h00, 2'd3, 0, 2'd0);
        // R3: access flag clear wins over user and exec faults
        step(1, dsc(0,0,0,0,1), 5'h00, 2'd1, 1, 2'd2);
        // R4: user without user right
        step(1, dsc(1,0,0,0,0), 5'h00, 2'd2, 1, 2'd0);
        // R2: table no-user clears user right, user access faults
        step(1, dsc(1,1,0,0,0), 5'h04, 2'd3, 1, 2'd0);
        // R5: privileged exec with leaf pxn faults
        step(1, dsc(1,1,0,1,0), 5'h00, 2'd2, 0, 2'd2);
        // R5: user exec with pxn only is allowed
        step(1, dsc(1,1,0,1,0), 5'h00, 2'd2, 1, 2'd2);
        // R5 R1: table xn removes execute on a read
        step(1, dsc(1,1,0,0,0), 5'h02, 2'd1, 0, 2'd0);
        // R6 R1: table write-protect faults a write
        step(1, dsc(1,1,0,0,0), 5'h08, 2'd2, 0, 2'd1);
        // R6: write-protect on a read removes write only
        step(1, dsc(1,1,1,0,0), 5'h00, 2'd1, 0, 2'd0);
        // R5 R6: exec with wprot and xn gives the exec fault
        step(1, dsc(1,1,1,0,1), 5'h00, 2'd3, 0, 2'd2);
        // R10: code 3 behaves as read under xn and wprot
        step(1, dsc(1,1,1,0,1), 5'h01, 2'd0, 0, 2'd3);
        // R9: hold with no request, twice
        step(0, 64'hFFFF_FFFF_FFFF_FFFF, 5'h1F, 2'd1, 1, 2'd1);
        step(0, 64'h0, 5'h0, 2'd0, 0, 2'd2);
        // R1: field copy with all-ones descriptor
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h00, 2'd1, 0, 2'd0);
        // Random mix, access flag mostly set
        for (int i = 0; i < 400; i++) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            if ($urandom_range(0, 7) != 0) d[10] = 1'b1;
            step(1'($urandom_range(0, 3) != 0), d, 5'($urandom), 2'($urandom),
                 1'($urandom), 2'($urandom));
        end
        // Mid-run reset clears the outputs, R9
        @(negedge clk);
        compare();
        rst_n = 1'b0; in_valid = 1'b0;
        e_valid = 0; e_fault = 0; e_code = 0; e_mask = 0; e_attr = 0;
        @(negedge clk);
        compare();
        rst_n = 1'b1;
        step(0, 64'h0, 5'h0, 2'd0, 0, 2'd0);
        @(negedge clk);
        compare();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule